// File: doc/BRIEF.md
# Width-Aliased Floating-Point Register File

This block stores floating-point state as one array of 32-bit words. Each port chooses how wide an operand it reads or writes: one word (single), two consecutive words (double) or four consecutive words (quad). In every wide operand, the lowest-numbered word is the most significant part. All three views share the same storage, so a double written at word 6 can be read back as two singles at words 6 and 7.

A build-time parameter selects the storage depth: 32 words or 64 words. In the 64-word build, the 5-bit register field of a double or quad access is remapped onto a 6-bit word index. The low field bit becomes index bit 5. This lets the upper 32 words be reached as doubles and quads, while single fields still reach only words 0 to 31.

There are two combinational read ports and one synchronous write port. None of these ports has a valid/ready handshake. A write is taken on every clock edge where it is enabled and legal. Reads never stall, so there is no back-pressure anywhere.

Top module: `fprf_alias_top`

## Requirements
- R1: After reset every word holds zero, so every legal read at any size returns all zeros.
- R2: Size code 0 (single) addresses word f directly, for fields 0 to 31. The read returns that word in data[31:0] with zeros above it. A write stores wr_data[31:0].
- R3: Size code 1 (double) at index n returns word n in data[63:32] and word n+1 in data[31:0], with data[127:64] zero. A double write stores wr_data[63:32] into word n and wr_data[31:0] into word n+1.
- R4: Size code 2 (quad) at index n returns words n, n+1, n+2 and n+3 in data[127:96], [95:64], [63:32] and [31:0]. A quad write stores the same slices into the same words.
- R5: In the 32-word build, a double field f maps to index f & 0x1E and a quad field maps to index f & 0x1C. No access with a size code of 0, 1 or 2 is ever flagged illegal.
- R6: In the 64-word build, a double or quad field f maps to index ((f & 1) << 5) | (f & 0x1E). Single fields still index words 0 to 31 directly.
- R7: In the 64-word build, a quad access whose field has bit 1 set is illegal. The read port raises its illegal flag and returns zero. A write raises wr_illegal and changes no word.
- R8: Size code 3 is reserved. A read with it is flagged illegal and returns zero. A write with it raises wr_illegal and changes no word.
- R9: A legal enabled write changes exactly 1, 2 or 4 words, according to its size. All other words keep their values.
- R10: A read that overlaps the word being written in the same cycle returns the old contents. The new value is visible from the next cycle.
- R11: The two read ports are independent. Given the same field and size, they return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; clears every word |
| rd_a_fld | input | 5 | Read port A register field |
| rd_a_size | input | 2 | Read port A size code (0 single, 1 double, 2 quad, 3 reserved) |
| rd_a_data | output | 128 | Read port A operand, right-aligned |
| rd_a_illegal | output | 1 | Read port A field/size combination is illegal |
| rd_b_fld | input | 5 | Read port B register field |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 128 | Read port B operand, right-aligned |
| rd_b_illegal | output | 1 | Read port B field/size combination is illegal |
| wr_en | input | 1 | Write request |
| wr_fld | input | 5 | Write register field |
| wr_size | input | 2 | Write size code |
| wr_data | input | 128 | Write operand, right-aligned |
| wr_illegal | output | 1 | Enabled write was rejected as illegal |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy uses the 64-word build (LARGE=1) and the other the 32-word build (LARGE=0). With two copies, the same field values reach different words: the bit-remapped upper half in one build, and the masked aligned slot in the other. The misaligned-quad rejection can only occur in the 64-word copy, while the 32-word copy must accept the same access.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 128;
  localparam int LANES  = OP_W / WORD_W;

  typedef enum logic [1:0] {
    SZ_SINGLE = 2'd0,
    SZ_DOUBLE = 2'd1,
    SZ_QUAD   = 2'd2,
    SZ_RSVD   = 2'd3
  } fp_size_e;
endpackage

// File: rtl/fprf_decode.sv
module fprf_decode
  import fprf_pkg::*;
#(
  parameter bit LARGE = 1'b1,
  parameter int IDXW  = 6
) (
  input  logic [4:0]      fld,
  input  logic [1:0]      size,
  output logic [IDXW-1:0] idx,
  output logic [2:0]      span,
  output logic            illegal
);
  always_comb begin
    idx     = '0;
    span    = 3'd0;
    illegal = 1'b0;
    unique case (fp_size_e'(size))
      SZ_SINGLE: begin
        idx  = IDXW'(fld);
        span = 3'd1;
      end
      SZ_DOUBLE: begin
        // wide build moves field bit 0 up to index bit 5
        if (LARGE) idx = IDXW'({fld[0], fld[4:1], 1'b0});
        else       idx = IDXW'({fld[4:1], 1'b0});
        span = 3'd2;
      end
      SZ_QUAD: begin
        if (LARGE) begin
          idx     = IDXW'({fld[0], fld[4:1], 1'b0});
          illegal = fld[1];
        end else begin
          idx = IDXW'({fld[4:2], 2'b00});
        end
        span = 3'd4;
      end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
  import fprf_pkg::*;
#(
  parameter int NWORDS = 64,
  parameter int IDXW   = 6
) (
  input  logic [NWORDS*WORD_W-1:0] words_flat,
  input  logic [IDXW-1:0]          idx,
  input  logic [2:0]               span,
  input  logic                     illegal,
  output logic [OP_W-1:0]          data
);
  always_comb begin
    logic [IDXW-1:0] wi;
    data = '0;
    wi   = '0;
    if (!illegal) begin
      for (int k = 0; k < LANES; k++) begin
        if (k < int'(span)) begin
          wi   = idx + IDXW'(k);
          // lowest word ends up most significant
          data = {data[OP_W-WORD_W-1:0], words_flat[WORD_W*int'(wi) +: WORD_W]};
        end
      end
    end
  end
endmodule

// File: rtl/fprf_write_ctl.sv
module fprf_write_ctl
  import fprf_pkg::*;
#(
  parameter int NWORDS = 64,
  parameter int IDXW   = 6
) (
  input  logic                            en,
  input  logic [IDXW-1:0]                 idx,
  input  logic [2:0]                      span,
  input  logic                            illegal,
  input  logic [OP_W-1:0]                 data,
  output logic [NWORDS-1:0]               we,
  output logic [NWORDS-1:0][WORD_W-1:0]   wdata
);
  logic [LANES-1:0][WORD_W-1:0] lanes;
  logic go;

  assign go = en && !illegal;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(span)) lanes[k] = data[WORD_W*(int'(span)-1-k) +: WORD_W];
      else                lanes[k] = '0;
    end
  end

  always_comb begin
    logic [IDXW-1:0] off;
    off = '0;
    for (int j = 0; j < NWORDS; j++) begin
      off      = IDXW'(j) - idx;
      we[j]    = go && (int'(off) < int'(span));
      wdata[j] = lanes[off[1:0]];
    end
  end
endmodule

// File: rtl/fprf_alias_top.sv
module fprf_alias_top
  import fprf_pkg::*;
#(
  parameter bit LARGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   rd_a_fld,
  input  logic [1:0]   rd_a_size,
  output logic [127:0] rd_a_data,
  output logic         rd_a_illegal,
  input  logic [4:0]   rd_b_fld,
  input  logic [1:0]   rd_b_size,
  output logic [127:0] rd_b_data,
  output logic         rd_b_illegal,
  input  logic         wr_en,
  input  logic [4:0]   wr_fld,
  input  logic [1:0]   wr_size,
  input  logic [127:0] wr_data,
  output logic         wr_illegal
);
  localparam int NWORDS = LARGE ? 64 : 32;
  localparam int IDXW   = $clog2(NWORDS);

  logic [NWORDS*WORD_W-1:0]          words_flat;
  logic [NWORDS-1:0]                 we;
  logic [NWORDS-1:0][WORD_W-1:0]     wdata;

  logic [IDXW-1:0] a_idx, b_idx, w_idx;
  logic [2:0]      a_span, b_span, w_span;
  logic            w_bad;

  fprf_decode #(.LARGE(LARGE), .IDXW(IDXW)) u_dec_a (
    .fld(rd_a_fld), .size(rd_a_size), .idx(a_idx), .span(a_span), .illegal(rd_a_illegal));
  fprf_decode #(.LARGE(LARGE), .IDXW(IDXW)) u_dec_b (
    .fld(rd_b_fld), .size(rd_b_size), .idx(b_idx), .span(b_span), .illegal(rd_b_illegal));
  fprf_decode #(.LARGE(LARGE), .IDXW(IDXW)) u_dec_w (
    .fld(wr_fld), .size(wr_size), .idx(w_idx), .span(w_span), .illegal(w_bad));

  fprf_read_port #(.NWORDS(NWORDS), .IDXW(IDXW)) u_rd_a (
    .words_flat(words_flat), .idx(a_idx), .span(a_span), .illegal(rd_a_illegal), .data(rd_a_data));
  fprf_read_port #(.NWORDS(NWORDS), .IDXW(IDXW)) u_rd_b (
    .words_flat(words_flat), .idx(b_idx), .span(b_span), .illegal(rd_b_illegal), .data(rd_b_data));

  fprf_write_ctl #(.NWORDS(NWORDS), .IDXW(IDXW)) u_wr (
    .en(wr_en), .idx(w_idx), .span(w_span), .illegal(w_bad), .data(wr_data),
    .we(we), .wdata(wdata));

  assign wr_illegal = wr_en && w_bad;

  for (genvar j = 0; j < NWORDS; j++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[j]) q <= wdata[j];
    end
    assign words_flat[WORD_W*j +: WORD_W] = q;
  end
endmodule

// File: rtl/fprf_chk.sv
module fprf_chk #(
  parameter bit LARGE = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   rd_a_fld,
  input logic [1:0]   rd_a_size,
  input logic [127:0] rd_a_data,
  input logic         rd_a_illegal,
  input logic [4:0]   rd_b_fld,
  input logic [1:0]   rd_b_size,
  input logic [127:0] rd_b_data,
  input logic         wr_en,
  input logic [4:0]   wr_fld,
  input logic [1:0]   wr_size,
  input logic [127:0] wr_data,
  input logic         wr_illegal
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_a_data == '0);
  // R2
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_size == 2'd0 |-> rd_a_data[127:32] == '0);
  // R3
  double_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_size == 2'd1 |-> rd_a_data[127:64] == '0);
  // R5
  small_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (LARGE == 1'b0 && rd_a_size != 2'd3) |-> !rd_a_illegal);
  // R7
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_illegal |-> rd_a_data == '0);
  // R8
  rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_size == 2'd3 |-> rd_a_illegal);
  // R7
  wr_illegal_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |-> wr_en);
  // R10
  single_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_illegal && wr_size == 2'd0) |=>
      (rd_a_size != 2'd0 || rd_a_fld != $past(wr_fld) ||
       rd_a_data[31:0] == $past(wr_data[31:0])));
  // R11
  ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_fld == rd_b_fld && rd_a_size == rd_b_size) |-> rd_a_data == rd_b_data);
endmodule

bind fprf_alias_top fprf_chk #(.LARGE(LARGE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_a_fld(rd_a_fld), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
  .rd_b_fld(rd_b_fld), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_fld(wr_fld), .wr_size(wr_size), .wr_data(wr_data), .wr_illegal(wr_illegal));

// File: tb/sim_fprf_alias_top.sv
module sim_fprf_alias_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]   af, bf, wf;
  logic [1:0]   as_, bs_, ws;
  logic         we;
  logic [127:0] wd;

  logic [127:0] la_d, lb_d, sa_d, sb_d;
  logic         la_i, lb_i, sa_i, sb_i, lw_i, sw_i;

  fprf_alias_top #(.LARGE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_fld(af), .rd_a_size(as_), .rd_a_data(la_d), .rd_a_illegal(la_i),
    .rd_b_fld(bf), .rd_b_size(bs_), .rd_b_data(lb_d), .rd_b_illegal(lb_i),
    .wr_en(we), .wr_fld(wf), .wr_size(ws), .wr_data(wd), .wr_illegal(lw_i));

  fprf_alias_top #(.LARGE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_fld(af), .rd_a_size(as_), .rd_a_data(sa_d), .rd_a_illegal(sa_i),
    .rd_b_fld(bf), .rd_b_size(bs_), .rd_b_data(sb_d), .rd_b_illegal(sb_i),
    .wr_en(we), .wr_fld(wf), .wr_size(ws), .wr_data(wd), .wr_illegal(sw_i));

  logic [31:0] ml [64];
  logic [31:0] ms [32];
  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";
  logic [31:0] seed = 32'h1234_5678;

  function automatic int midx(bit lg, int f, int sz);
    if (sz == 0) return f;
    if (lg) return ((f & 1) << 5) | (f & 30);
    return (sz == 1) ? (f & 30) : (f & 28);
  endfunction

  function automatic bit mbad(bit lg, int f, int sz);
    if (sz == 3) return 1'b1;
    return lg && sz == 2 && (midx(lg, f, sz) % 4) != 0;
  endfunction

  function automatic int mspan(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [127:0] mread(bit lg, int f, int sz);
    logic [127:0] r = '0;
    int n;
    if (mbad(lg, f, sz)) return '0;
    n = midx(lg, f, sz);
    for (int k = 0; k < mspan(sz); k++)
      r = (r << 32) | {96'd0, (lg ? ml[n+k] : ms[n+k])};
    return r;
  endfunction

  task automatic chk(string what, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic mwrite(bit lg);
    int n, s;
    if (!we || mbad(lg, wf, ws)) return;
    n = midx(lg, wf, ws);
    s = mspan(ws);
    for (int k = 0; k < s; k++) begin
      if (lg) ml[n+k] = wd[32*(s-1-k) +: 32];
      else    ms[n+k] = wd[32*(s-1-k) +: 32];
    end
  endtask

  task automatic cyc(input int a_f, input int a_s, input int b_f, input int b_s,
                     input bit w_e, input int w_f, input int w_s, input logic [127:0] w_d);
    @(negedge clk);
    af = 5'(a_f); as_ = 2'(a_s); bf = 5'(b_f); bs_ = 2'(b_s);
    we = w_e; wf = 5'(w_f); ws = 2'(w_s); wd = w_d;
    #1;
    chk("large A data", la_d, mread(1'b1, a_f, a_s));
    chk("large A illegal", {127'd0, la_i}, {127'd0, mbad(1'b1, a_f, a_s)});
    chk("large B data", lb_d, mread(1'b1, b_f, b_s));
    chk("large B illegal", {127'd0, lb_i}, {127'd0, mbad(1'b1, b_f, b_s)});
    chk("large wr_illegal", {127'd0, lw_i}, {127'd0, w_e && mbad(1'b1, w_f, w_s)});
    chk("small A data", sa_d, mread(1'b0, a_f, a_s));
    chk("small A illegal", {127'd0, sa_i}, {127'd0, mbad(1'b0, a_f, a_s)});
    chk("small B data", sb_d, mread(1'b0, b_f, b_s));
    chk("small B illegal", {127'd0, sb_i}, {127'd0, mbad(1'b0, b_f, b_s)});
    chk("small wr_illegal", {127'd0, sw_i}, {127'd0, w_e && mbad(1'b0, w_f, w_s)});
    @(posedge clk);
    #1;
    mwrite(1'b1);
    mwrite(1'b0);
  endtask

  task automatic rnd(output logic [31:0] v);
    seed = seed * 32'd1664525 + 32'd1013904223;
    v = seed;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1, r2, r3, r4;
    for (int i = 0; i < 64; i++) ml[i] = '0;
    for (int i = 0; i < 32; i++) ms[i] = '0;
    af = '0; bf = '0; wf = '0; as_ = '0; bs_ = '0; ws = '0; we = 1'b0; wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    tag = "R1";
    cyc(3, 0, 4, 1, 0, 0, 0, '0);
    cyc(8, 2, 31, 0, 0, 0, 0, '0);
    tag = "R2";
    cyc(0, 0, 0, 0, 1, 5, 0, 128'hDEAD_BEEF_0000_AAAA_5555_1111_CAFE_F00D);
    cyc(5, 0, 4, 0, 0, 0, 0, '0);
    tag = "R3";
    cyc(0, 0, 0, 0, 1, 6, 1, 128'h1111_2222_3333_4444);
    cyc(6, 1, 7, 0, 0, 0, 0, '0);
    tag = "R4";
    cyc(0, 0, 0, 0, 1, 8, 2, 128'hA0A0_0001_B0B0_0002_C0C0_0003_D0D0_0004);
    cyc(8, 2, 11, 0, 0, 0, 0, '0);
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 9, 1, 128'h9999_0000_8888_0000);
    cyc(8, 1, 9, 1, 1, 13, 2, 128'h1_0000_0002_0000_0003_0000_0004);
    cyc(12, 2, 13, 2, 0, 0, 0, '0);
    tag = "R6";
    cyc(0, 0, 0, 0, 1, 1, 1, 128'h7777_6666_5555_4444);
    cyc(0, 0, 1, 0, 0, 0, 0, '0);
    cyc(1, 1, 31, 0, 0, 0, 0, '0);
    tag = "R7";
    cyc(2, 2, 0, 2, 1, 2, 2, 128'hFFFF_EEEE_DDDD_CCCC_BBBB_AAAA_9999_8888);
    cyc(2, 2, 2, 1, 0, 0, 0, '0);
    tag = "R8";
    cyc(4, 3, 4, 0, 1, 4, 3, 128'h1234);
    cyc(4, 0, 5, 0, 0, 0, 0, '0);
    tag = "R10";
    cyc(12, 0, 12, 1, 1, 12, 0, 128'h0BAD_F00D);
    cyc(12, 0, 12, 1, 0, 0, 0, '0);
    tag = "R11";
    cyc(6, 1, 6, 1, 0, 0, 0, '0);
    cyc(8, 2, 1, 1, 0, 0, 0, '0);
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      rnd(r0); rnd(r1); rnd(r2); rnd(r3); rnd(r4);
      cyc(int'(r4[4:0]), int'(r4[6:5]), int'(r4[11:7]), int'(r4[13:12]),
          r4[14] | r4[15], int'(r4[20:16]), int'(r4[22:21]), {r0, r1, r2, r3});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule